// File: doc/BRIEF.md
# Integer ALU with Compare

This block is the integer arithmetic and logic unit of a processor core's execute stage. It is purely combinational: two operand words, a shift count and an operation code go in. The result word and an all-zero indicator come out in the same cycle. The branch unit uses the all-zero indicator to decide equality after a subtraction.

One adder serves addition, subtraction and the signed less-than compare. Subtraction is formed as A plus the inverted B plus a carry-in of one. The compare uses the sign of that difference together with the operand signs, so it gives the right answer even when the difference overflows.

Shifts take their count from a dedicated shift-amount input and ignore operand B. A bitwise complement is obtained by selecting NOR with B held at zero. The data width is a parameter, and the shift-amount width is derived from it. The adder style and the shifter style are each chosen by a parameter.

Top module: `intalu`

## Requirements
- R1: With `op_sel` = 4'h0 (add), `result` equals `opa + opb` modulo 2^32.
- R2: With `op_sel` = 4'h1 (subtract), `result` equals `opa - opb` modulo 2^32, formed as `opa + ~opb + 1` in the shared adder.
- R3: Add and subtract wrap silently with no flag raised: 0xFFFFFFFF + 1 gives 0 with `zero` = 1, 0x7FFFFFFF + 1 gives 0x80000000, and 0 - 1 gives 0xFFFFFFFF.
- R4: Codes 4'h2, 4'h3 and 4'h4 give bitwise AND, OR and NOR of `opa` and `opb`. NOR with `opb` = 0 gives `~opa`.
- R5: Code 4'h5 shifts `opa` left by `shamt` (0 to 31), and code 4'h6 shifts it right logically. Vacated bits fill with zero, and `opb` has no effect on either shift.
- R6: Code 4'h7 gives 32'd1 when `opa` is less than `opb` as signed two's complement values, and 32'd0 otherwise. This holds across overflow: 0x80000000 vs 1 gives 1, and 0x7FFFFFFF vs 0xFFFFFFFF gives 0.
- R7: `zero` is 1 exactly when `result` is 0, for every operation code.
- R8: Codes 4'h8 to 4'hF give `result` = 0 and `zero` = 1.
- R9: `shamt` has no effect on codes other than 4'h5 and 4'h6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code |
| opa | input | 32 | First operand; value shifted by shift codes |
| opb | input | 32 | Second operand |
| shamt | input | 5 | Shift count for shift codes |
| result | output | 32 | Operation result |
| zero | output | 1 | High when `result` is all zeros |

## Verification
The block has no state, so any fault shows at `result` or `zero` in the same cycle its inputs are applied.

A broken carry link in the adder corrupts add, subtract and the compare only when a carry has to cross that bit. Random operands and full-carry corners such as all-ones plus one are therefore needed.

A wrong barrel stage shows only for shift counts that have that count bit set. The bench sweeps all 32 counts in both directions.

A faulty compare is hidden unless the operand signs differ or the difference overflows, so those sign pairs are driven on purpose.

// File: rtl/intalu_pkg.sv
package intalu_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_ADD = 4'h0,
      OP_SUB = 4'h1,
      OP_AND = 4'h2,
      OP_OR  = 4'h3,
      OP_NOR = 4'h4,
      OP_SLL = 4'h5,
      OP_SRL = 4'h6,
      OP_SLT = 4'h7
   } op_e;

   typedef enum logic [1:0] {
      BW_AND = 2'd0,
      BW_OR  = 2'd1,
      BW_NOR = 2'd2
   } bw_fn_e;

   function automatic logic op_needs_sub(input logic [OP_W-1:0] op);
      return (op == OP_SUB) || (op == OP_SLT);
   endfunction

endpackage

// File: rtl/intalu_addsub.sv
module intalu_addsub #(
   parameter int DATA_W = 32,
   parameter int STYLE  = 0      // 0: explicit ripple chain, 1: inferred adder
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              sub,
   output logic [DATA_W-1:0] sum
);

   logic [DATA_W-1:0] b_eff;
   assign b_eff = sub ? ~b : b;

   generate
      if (STYLE == 0) begin : g_ripple
         logic [DATA_W-1:0] cy;
         assign cy[0] = sub;
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign sum[i] = a[i] ^ b_eff[i] ^ cy[i];
            if (i < DATA_W - 1) begin : g_carry
               assign cy[i+1] = (a[i] & b_eff[i]) | (cy[i] & (a[i] ^ b_eff[i]));
            end
         end
      end else if (STYLE == 1) begin : g_infer
         assign sum = a + b_eff + {{(DATA_W-1){1'b0}}, sub};
      end else begin : g_bad_style
         $error("intalu_addsub: STYLE must be 0 or 1");
      end
   endgenerate

   always_comb begin
      if (sub) begin
         assert_sub_wraps_R2: assert (sum == a - b)
            else $error("subtract path disagrees with a-b");
      end else begin
         assert_add_wraps_R3: assert (sum == a + b)
            else $error("add path disagrees with a+b");
      end
   end

endmodule

// File: rtl/intalu_shift.sv
module intalu_shift #(
   parameter int DATA_W  = 32,
   parameter int SHAMT_W = 5,
   parameter int STYLE   = 0     // 0: log-stage barrel, 1: inferred shift operators
) (
   input  logic [DATA_W-1:0]  din,
   input  logic [SHAMT_W-1:0] amt,
   input  logic               left,
   output logic [DATA_W-1:0]  dout
);

   generate
      if ((1 << SHAMT_W) != DATA_W) begin : g_bad_width
         $error("intalu_shift: 2**SHAMT_W must equal DATA_W");
      end

      if (STYLE == 0) begin : g_barrel
         function automatic logic [DATA_W-1:0] flip(input logic [DATA_W-1:0] v);
            logic [DATA_W-1:0] r;
            for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
            return r;
         endfunction

         logic [DATA_W-1:0] stg [SHAMT_W+1];
         assign stg[0] = left ? flip(din) : din;
         for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
            assign stg[k+1] = amt[k] ? (stg[k] >> (2**k)) : stg[k];
         end
         assign dout = left ? flip(stg[SHAMT_W]) : stg[SHAMT_W];
      end else if (STYLE == 1) begin : g_infer
         assign dout = left ? (din << amt) : (din >> amt);
      end else begin : g_bad_style
         $error("intalu_shift: STYLE must be 0 or 1");
      end
   endgenerate

   always_comb begin
      if (amt == '0) begin
         assert_zero_amt_identity_R5: assert (dout == din)
            else $error("shift by zero altered the operand");
      end
      if (amt != '0) begin
         if (left) begin
            assert_left_zero_fill_R5: assert (dout[0] == 1'b0)
               else $error("left shift did not fill bit 0 with zero");
         end else begin
            assert_right_zero_fill_R5: assert (dout[DATA_W-1] == 1'b0)
               else $error("right shift did not fill top bit with zero");
         end
      end
   end

endmodule

// File: rtl/intalu_bitwise.sv
module intalu_bitwise
   import intalu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  bw_fn_e            fn,
   output logic [DATA_W-1:0] y
);

   always_comb begin
      unique case (fn)
         BW_AND:  y = a & b;
         BW_OR:   y = a | b;
         BW_NOR:  y = ~(a | b);
         default: y = '0;
      endcase
   end

   always_comb begin
      if (fn == BW_NOR && b == '0) begin
         assert_nor_as_not_R4: assert (y == ~a)
            else $error("NOR with zero is not the complement");
      end
   end

endmodule

// File: rtl/intalu.sv
module intalu
   import intalu_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADD_STYLE   = 0,
   parameter int SHIFT_STYLE = 0,
   localparam int SHAMT_W    = $clog2(DATA_W)
) (
   input  logic [OP_W-1:0]    op_sel,
   input  logic [DATA_W-1:0]  opa,
   input  logic [DATA_W-1:0]  opb,
   input  logic [SHAMT_W-1:0] shamt,
   output logic [DATA_W-1:0]  result,
   output logic               zero
);

   localparam int MSB = DATA_W - 1;

   generate
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("intalu: DATA_W must be a power of two of at least 8");
      end
   endgenerate

   logic [DATA_W-1:0] sum_w, shift_w, bit_w;
   logic              sub_w, left_w, lt_w;
   bw_fn_e            bw_fn;

   assign sub_w  = op_needs_sub(op_sel);
   assign left_w = (op_sel == OP_SLL);

   always_comb begin
      if (op_sel == OP_AND)     bw_fn = BW_AND;
      else if (op_sel == OP_OR) bw_fn = BW_OR;
      else                      bw_fn = BW_NOR;
   end

   intalu_addsub #(.DATA_W(DATA_W), .STYLE(ADD_STYLE)) u_addsub (
      .a   (opa),
      .b   (opb),
      .sub (sub_w),
      .sum (sum_w)
   );

   intalu_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .STYLE(SHIFT_STYLE)) u_shift (
      .din  (opa),
      .amt  (shamt),
      .left (left_w),
      .dout (shift_w)
   );

   intalu_bitwise #(.DATA_W(DATA_W)) u_bitwise (
      .a  (opa),
      .b  (opb),
      .fn (bw_fn),
      .y  (bit_w)
   );

   // Signs differ: the negative operand is smaller; otherwise the difference cannot overflow.
   assign lt_w = (opa[MSB] ^ opb[MSB]) ? opa[MSB] : sum_w[MSB];

   always_comb begin
      case (op_sel)
         OP_ADD, OP_SUB:         result = sum_w;
         OP_AND, OP_OR, OP_NOR:  result = bit_w;
         OP_SLL, OP_SRL:         result = shift_w;
         OP_SLT:                 result = {{(DATA_W-1){1'b0}}, lt_w};
         default:                result = '0;
      endcase
   end

   assign zero = ~|result;

   always_comb begin
      if (op_sel == OP_SLT) begin
         assert_slt_signed_R6: assert (result == {{(DATA_W-1){1'b0}}, ($signed(opa) < $signed(opb))})
            else $error("signed compare result wrong");
      end
      assert_zero_flag_R7: assert (zero == (result == '0))
         else $error("zero flag inconsistent with result");
      if (op_sel > OP_SLT) begin
         assert_unused_code_R8: assert (result == '0 && zero)
            else $error("unused code produced nonzero result");
      end
   end

endmodule

// File: tb/test_intalu.sv
module test_intalu;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op_sel = '0;
   logic [31:0] opa = '0, opb = '0;
   logic [4:0]  shamt = '0;
   logic [31:0] result;
   logic        zero;

   int checks = 0;
   int errors = 0;

   logic [31:0] q_res[$];
   logic        q_zero[$];
   logic [3:0]  q_op[$];
   string       q_tag[$];

   always #5 clk = ~clk;

   intalu i_intalu (
      .op_sel (op_sel),
      .opa    (opa),
      .opb    (opb),
      .shamt  (shamt),
      .result (result),
      .zero   (zero)
   );

   function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                         input logic [31:0] b, input logic [4:0] s);
      case (op)
         4'h0: return a + b;
         4'h1: return a - b;
         4'h2: return a & b;
         4'h3: return a | b;
         4'h4: return ~(a | b);
         4'h5: return a << s;
         4'h6: return a >> s;
         4'h7: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
         default: return 32'd0;
      endcase
   endfunction

   function automatic string tag_of(input logic [3:0] op);
      case (op)
         4'h0: return "R1";
         4'h1: return "R2";
         4'h2, 4'h3, 4'h4: return "R4";
         4'h5, 4'h6: return "R5";
         4'h7: return "R6";
         default: return "R8";
      endcase
   endfunction

   // Driver: apply one operation on a falling edge and queue its expectation.
   task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [4:0] s, input string tag);
      logic [31:0] e;
      @(negedge clk);
      op_sel = op; opa = a; opb = b; shamt = s;
      e = model(op, a, b, s);
      q_res.push_back(e);
      q_zero.push_back(e == 32'd0);
      q_op.push_back(op);
      q_tag.push_back(tag);
   endtask

   // Monitor: compare on the rising edge after each applied item.
   always @(posedge clk) begin
      if (q_res.size() != 0) begin
         logic [31:0] er;
         logic        ez;
         logic [3:0]  eo;
         string       et;
         er = q_res.pop_front();
         ez = q_zero.pop_front();
         eo = q_op.pop_front();
         et = q_tag.pop_front();
         checks++;
         if (result !== er) begin
            errors++;
            $display("FAIL %s: op=%0h a=%h b=%h sh=%0d result=%h expected=%h",
                     et, eo, opa, opb, shamt, result, er);
         end
         checks++;
         if (zero !== ez) begin
            errors++;
            $display("FAIL R7: op=%0h zero=%b expected=%b", eo, zero, ez);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      // idle state: all-zero inputs decode as 0+0 (R1, R7)
      checks++;
      if (result !== 32'd0 || zero !== 1'b1) begin
         errors++;
         $display("FAIL R1: idle result=%h zero=%b expected=00000000 1", result, zero);
      end
      rst_n = 1'b1;

      // R3 wrap corners
      drive(4'h0, 32'hFFFF_FFFF, 32'd1, 5'd0, "R3");
      drive(4'h0, 32'h7FFF_FFFF, 32'd1, 5'd0, "R3");
      drive(4'h1, 32'd0, 32'd1, 5'd0, "R3");
      drive(4'h1, 32'h8000_0000, 32'd1, 5'd0, "R3");
      drive(4'h1, 32'h1234_5678, 32'h1234_5678, 5'd0, "R2");
      // R4 complement via NOR
      drive(4'h4, 32'hA5A5_0F0F, 32'd0, 5'd0, "R4");
      drive(4'h4, 32'h0, 32'd0, 5'd0, "R4");
      drive(4'h2, 32'hFFFF_0000, 32'h0FF0_0FF0, 5'd0, "R4");
      drive(4'h3, 32'hF000_0000, 32'h0000_000F, 5'd0, "R4");
      // R6 signed compare corners
      drive(4'h7, 32'h8000_0000, 32'd1, 5'd0, "R6");
      drive(4'h7, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0, "R6");
      drive(4'h7, 32'hFFFF_FFFF, 32'd0, 5'd0, "R6");
      drive(4'h7, 32'd5, 32'd5, 5'd0, "R6");
      drive(4'h7, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0, "R6");
      drive(4'h7, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0, "R6");
      // R5 every shift count both directions, opb noise must not matter
      for (int s = 0; s < 32; s++) begin
         drive(4'h5, 32'h8000_0001 ^ (32'h1 << s), $urandom, 5'(s), "R5");
         drive(4'h6, 32'hC000_0003, $urandom, 5'(s), "R5");
      end
      // R8 every unused code
      for (int c = 8; c < 16; c++) begin
         drive(4'(c), $urandom, $urandom, 5'($urandom), "R8");
      end
      // R9 shift count has no effect on non-shift codes
      for (int c = 0; c < 5; c++) begin
         drive(4'(c), 32'hDEAD_BEEF, 32'h0BAD_F00D, 5'd31, "R9");
      end
      drive(4'h7, 32'h8000_0000, 32'd1, 5'd17, "R9");
      // random sweep over every code
      for (int n = 0; n < 1600; n++) begin
         logic [3:0]  op;
         logic [31:0] a, b;
         op = 4'($urandom_range(0, 15));
         a  = $urandom;
         b  = (n % 7 == 0) ? a : $urandom;
         if (n % 11 == 0) a = a | 32'h8000_0000;
         drive(op, a, b, 5'($urandom), tag_of(op));
      end
      @(negedge clk);
      @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule